// File: doc/BRIEF.md
# Transmit-then-Receive Modem Phase Sequencer

This block steps a contactless reader front end through one half-duplex exchange. The exchange runs in order: wait for a send trigger, wait out a minimum delay before transmitting, transmit, wait out a second minimum delay before listening, wait for the first incoming data, and receive. At every moment the block reports the phase it is in as a fixed 3-bit code. It drives a transmit enable and a receive enable for the analog and coding stages, and it pulses a completion flag once the received frame ends. Each of the two delays can also be held until an RF carrier is reported present.

A small status byte lets a host read the current phase code next to a cipher-active flag. Only a successful authentication event can set that flag, and only a software write can clear it. A separate sticky over-temperature error is set by the thermal comparator. Software can clear it, but only while the temperature is back under the alarm limit. The block contains no modulation, bit coding, framing, cipher logic or host bus. Those parts sit around it and talk to it through the ports listed below.

Top module: `modem_seq`

## Requirements
- R1: The phase code takes only the values 000 idle, 001 awaiting send trigger, 010 pre-transmit delay, 011 transmitting, 100 pre-receive delay, 101 awaiting data, 110 receiving. The value 111 never appears.
- R2: From idle, the block moves to 001 on the clock after `cmdActive` is high. It leaves 001, to 010, only on a clock where `startSend` is high.
- R3: Number the cycles spent in 010 as k = 0, 1, 2, ... from entry. The block moves to 011 after the first cycle in which k >= `txWaitCount` and the RF condition is met. With a count of 0 and no RF hold, the block stays in 010 for exactly one cycle.
- R4: While `waitRfEn` is high, both 010 and 100 hold for as long as `rfPresent` is low, even after their delay count has expired.
- R5: State 100 uses the same exit rule as R3, but it takes its minimum from `rxWaitCount`. That count is independent of `txWaitCount`.
- R6: 011 moves to 100 on `txDone`. 101 moves to 110 on `rxStart`. 110 moves to 000 on `rxDone`.
- R7: If `abort` is high or `cmdActive` is low, the phase is 000 on the next clock, whatever the current phase. This rule overrides every other transition.
- R8: `done` is high for exactly one cycle. That cycle is the first cycle in idle after 110 was left through `rxDone`. An abort never produces `done`.
- R9: `txEn` is high exactly in phase 011. `rxEn` is high exactly in phases 101 and 110.
- R10: Status bit 3, cipher active, is set by `authOk`. A status write with `regWrCipher` = 0 clears it. A write with `regWrCipher` = 1 has no effect on it. When `authOk` and a clearing write come in the same cycle, the bit is set.
- R11: `tempError` is set while `overTemp` is high and stays set afterwards. A status write with `regWrTempClr` = 1 clears it, but only if `overTemp` is low in that cycle.
- R12: `statusReg` reads {0000, cipher active, phase code}. It reads 00h after reset, and bits 7 to 4 are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdActive | input | 1 | A transceive command is running |
| startSend | input | 1 | Send trigger |
| rfPresent | input | 1 | RF carrier detected |
| waitRfEn | input | 1 | Hold both delays until the carrier is present |
| txWaitCount | input | CNT_W | Minimum pre-transmit delay, in cycles |
| rxWaitCount | input | CNT_W | Minimum pre-receive delay, in cycles |
| txDone | input | 1 | Transmit stage finished |
| rxStart | input | 1 | First incoming data detected |
| rxDone | input | 1 | Received frame ended |
| abort | input | 1 | Return to idle |
| authOk | input | 1 | Successful authentication event |
| overTemp | input | 1 | Temperature above the alarm limit |
| regWrEn | input | 1 | Status write strobe |
| regWrCipher | input | 1 | Written value of the cipher-active bit |
| regWrTempClr | input | 1 | Written temperature-clear request |
| stateCode | output | 3 | Current phase code |
| txEn | output | 1 | Transmit enable |
| rxEn | output | 1 | Receive enable |
| done | output | 1 | One-cycle exchange-complete pulse |
| statusReg | output | 8 | Status readback byte |
| tempError | output | 1 | Sticky over-temperature error |

## Verification
The phase is visible on `stateCode` in every cycle, so a wrong transition shows up on the very next clock, either as an early or late code or as the wrong enable. A wait counter that fails to restart or compares against the wrong count moves the 010 to 011 or 100 to 101 step by a number of cycles equal to the error. A reference model that runs in lockstep catches that shift at the first divergent cycle. A mistake in the status bits stays hidden until the next authentication event, status write or thermal change, and then appears on the following clock.

// File: rtl/modem_seq_pkg.sv
package modem_seq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE      = 3'b000,
    PH_WAIT_SEND = 3'b001,
    PH_TX_DELAY  = 3'b010,
    PH_TX        = 3'b011,
    PH_RX_DELAY  = 3'b100,
    PH_WAIT_DATA = 3'b101,
    PH_RX        = 3'b110
  } phase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic cntRestart;
    logic selRx;
    logic doneSet;
  } seqStrobe_t;

endpackage

// File: rtl/modem_seq_ctrl.sv
module modem_seq_ctrl
  import modem_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdActive,
  input  logic       startSend,
  input  logic       rfPresent,
  input  logic       waitRfEn,
  input  logic       txDone,
  input  logic       rxStart,
  input  logic       rxDone,
  input  logic       abort,
  input  logic       waitExpired,
  output phase_e     phase,
  output seqStrobe_t strobe,
  output logic       txEn,
  output logic       rxEn
);

  phase_e nextPhase;
  logic   rfOk;
  logic   goIdle;

  assign rfOk   = !waitRfEn || rfPresent;
  assign goIdle = abort || !cmdActive;

  always_comb begin
    nextPhase = phase;
    if (goIdle) begin
      nextPhase = PH_IDLE;
    end else begin
      unique case (phase)
        PH_IDLE:      nextPhase = PH_WAIT_SEND;
        PH_WAIT_SEND: if (startSend) nextPhase = PH_TX_DELAY;
        PH_TX_DELAY:  if (waitExpired && rfOk) nextPhase = PH_TX;
        PH_TX:        if (txDone) nextPhase = PH_RX_DELAY;
        PH_RX_DELAY:  if (waitExpired && rfOk) nextPhase = PH_WAIT_DATA;
        PH_WAIT_DATA: if (rxStart) nextPhase = PH_RX;
        PH_RX:        if (rxDone) nextPhase = PH_IDLE;
        default:      nextPhase = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= PH_IDLE;
    else       phase <= nextPhase;
  end

  always_comb begin
    strobe.cntRestart = (nextPhase != phase);
    strobe.selRx      = (phase == PH_RX_DELAY);
    strobe.doneSet    = !goIdle && (phase == PH_RX) && rxDone;
  end

  assign txEn = (phase == PH_TX);
  assign rxEn = (phase == PH_WAIT_DATA) || (phase == PH_RX);

endmodule

// File: rtl/modem_seq_dp.sv
module modem_seq_dp
  import modem_seq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strobe,
  input  phase_e           phase,
  input  logic [CNT_W-1:0] txWaitCount,
  input  logic [CNT_W-1:0] rxWaitCount,
  input  logic             authOk,
  input  logic             overTemp,
  input  logic             regWrEn,
  input  logic             regWrCipher,
  input  logic             regWrTempClr,
  output logic             waitExpired,
  output logic             done,
  output logic [7:0]       statusReg,
  output logic             tempError
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] waitCnt;
  logic [CNT_W-1:0] minSel;
  logic             cipherOn;

  // one shared delay counter, restarted on every phase change
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  waitCnt <= '0;
    else if (strobe.cntRestart) waitCnt <= '0;
    else if (waitCnt != CNT_MAX) waitCnt <= waitCnt + 1'b1;
  end

  assign minSel      = strobe.selRx ? rxWaitCount : txWaitCount;
  assign waitExpired = (waitCnt >= minSel);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) done <= 1'b0;
    else       done <= strobe.doneSet;
  end

  // authentication wins over a clearing write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         cipherOn <= 1'b0;
    else if (authOk)                   cipherOn <= 1'b1;
    else if (regWrEn && !regWrCipher)  cipherOn <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          tempError <= 1'b0;
    else if (overTemp)                  tempError <= 1'b1;
    else if (regWrEn && regWrTempClr)   tempError <= 1'b0;
  end

  assign statusReg = {4'b0000, cipherOn, phase};

endmodule

// File: rtl/modem_seq.sv
module modem_seq
  import modem_seq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdActive,
  input  logic             startSend,
  input  logic             rfPresent,
  input  logic             waitRfEn,
  input  logic [CNT_W-1:0] txWaitCount,
  input  logic [CNT_W-1:0] rxWaitCount,
  input  logic             txDone,
  input  logic             rxStart,
  input  logic             rxDone,
  input  logic             abort,
  input  logic             authOk,
  input  logic             overTemp,
  input  logic             regWrEn,
  input  logic             regWrCipher,
  input  logic             regWrTempClr,
  output logic [2:0]       stateCode,
  output logic             txEn,
  output logic             rxEn,
  output logic             done,
  output logic [7:0]       statusReg,
  output logic             tempError
);

  phase_e     phase;
  seqStrobe_t strobe;
  logic       waitExpired;

  modem_seq_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .cmdActive   (cmdActive),
    .startSend   (startSend),
    .rfPresent   (rfPresent),
    .waitRfEn    (waitRfEn),
    .txDone      (txDone),
    .rxStart     (rxStart),
    .rxDone      (rxDone),
    .abort       (abort),
    .waitExpired (waitExpired),
    .phase       (phase),
    .strobe      (strobe),
    .txEn        (txEn),
    .rxEn        (rxEn)
  );

  modem_seq_dp #(.CNT_W(CNT_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .phase        (phase),
    .txWaitCount  (txWaitCount),
    .rxWaitCount  (rxWaitCount),
    .authOk       (authOk),
    .overTemp     (overTemp),
    .regWrEn      (regWrEn),
    .regWrCipher  (regWrCipher),
    .regWrTempClr (regWrTempClr),
    .waitExpired  (waitExpired),
    .done         (done),
    .statusReg    (statusReg),
    .tempError    (tempError)
  );

  assign stateCode = phase;

endmodule

// File: rtl/modem_seq_chk.sv
module modem_seq_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             cmdActive,
  input logic             startSend,
  input logic             rfPresent,
  input logic             waitRfEn,
  input logic [CNT_W-1:0] txWaitCount,
  input logic [CNT_W-1:0] rxWaitCount,
  input logic             txDone,
  input logic             abort,
  input logic             authOk,
  input logic             overTemp,
  input logic             regWrEn,
  input logic             regWrTempClr,
  input logic [2:0]       stateCode,
  input logic             txEn,
  input logic             rxEn,
  input logic             done,
  input logic [7:0]       statusReg,
  input logic             tempError
);

  localparam logic [CNT_W:0] LEN_MAX = '1;

  logic [2:0]     prevCode;
  logic [CNT_W:0] lenQ;
  logic [CNT_W:0] kNow;
  logic           run;

  assign run  = cmdActive && !abort;
  assign kNow = (stateCode != prevCode) ? '0 :
                ((lenQ == LEN_MAX) ? lenQ : lenQ + 1'b1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevCode <= 3'b000;
      lenQ     <= '0;
    end else begin
      prevCode <= stateCode;
      lenQ     <= kNow;
    end
  end

  AST_NO_CODE7: assert property (@(posedge clk) disable iff (!rstN)
    stateCode != 3'b111); // R1
  AST_SEND_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (stateCode == 3'b001 && !startSend && run) |=> stateCode == 3'b001); // R2
  AST_TX_MIN_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    (stateCode == 3'b011 && $past(stateCode) == 3'b010)
      |-> $past(kNow) >= {1'b0, $past(txWaitCount)}); // R3
  AST_RF_HOLD_TX: assert property (@(posedge clk) disable iff (!rstN)
    (stateCode == 3'b010 && waitRfEn && !rfPresent && run) |=> stateCode == 3'b010); // R4
  AST_RF_HOLD_RX: assert property (@(posedge clk) disable iff (!rstN)
    (stateCode == 3'b100 && waitRfEn && !rfPresent && run) |=> stateCode == 3'b100); // R4
  AST_RX_MIN_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    (stateCode == 3'b101 && $past(stateCode) == 3'b100)
      |-> $past(kNow) >= {1'b0, $past(rxWaitCount)}); // R5
  AST_TX_EXIT: assert property (@(posedge clk) disable iff (!rstN)
    (stateCode == 3'b011 && txDone && run) |=> stateCode == 3'b100); // R6
  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (abort || !cmdActive) |=> stateCode == 3'b000); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R8
  AST_DONE_ORIGIN: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ($past(stateCode) == 3'b110 && stateCode == 3'b000)); // R8
  AST_TXEN_PHASE: assert property (@(posedge clk) disable iff (!rstN)
    txEn |-> (stateCode == 3'b011 && !rxEn)); // R9
  AST_RXEN_PHASE: assert property (@(posedge clk) disable iff (!rstN)
    rxEn |-> (stateCode == 3'b101 || stateCode == 3'b110)); // R9
  AST_CIPHER_SET: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusReg[3]) |-> $past(authOk)); // R10
  AST_TEMP_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    $fell(tempError) |-> $past(regWrEn && regWrTempClr && !overTemp)); // R11
  AST_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    statusReg[7:4] == 4'b0000); // R12

endmodule

bind modem_seq modem_seq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .cmdActive    (cmdActive),
  .startSend    (startSend),
  .rfPresent    (rfPresent),
  .waitRfEn     (waitRfEn),
  .txWaitCount  (txWaitCount),
  .rxWaitCount  (rxWaitCount),
  .txDone       (txDone),
  .abort        (abort),
  .authOk       (authOk),
  .overTemp     (overTemp),
  .regWrEn      (regWrEn),
  .regWrTempClr (regWrTempClr),
  .stateCode    (stateCode),
  .txEn         (txEn),
  .rxEn         (rxEn),
  .done         (done),
  .statusReg    (statusReg),
  .tempError    (tempError)
);

// File: tb/tb_modem_seq.sv
`timescale 1ns/1ps
module tb_modem_seq;

  localparam int CNT_W = 8;
  localparam int CNT_SAT = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdActive = 0, startSend = 0, rfPresent = 0, waitRfEn = 0;
  logic [CNT_W-1:0] txWaitCount = '0, rxWaitCount = '0;
  logic txDone = 0, rxStart = 0, rxDone = 0, abort = 0;
  logic authOk = 0, overTemp = 0, regWrEn = 0, regWrCipher = 0, regWrTempClr = 0;
  logic [2:0] stateCode;
  logic txEn, rxEn, done, tempError;
  logic [7:0] statusReg;

  always #2 clk = ~clk; // 250 MHz

  modem_seq #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rstN(rstN), .cmdActive(cmdActive), .startSend(startSend),
    .rfPresent(rfPresent), .waitRfEn(waitRfEn), .txWaitCount(txWaitCount),
    .rxWaitCount(rxWaitCount), .txDone(txDone), .rxStart(rxStart),
    .rxDone(rxDone), .abort(abort), .authOk(authOk), .overTemp(overTemp),
    .regWrEn(regWrEn), .regWrCipher(regWrCipher), .regWrTempClr(regWrTempClr),
    .stateCode(stateCode), .txEn(txEn), .rxEn(rxEn), .done(done),
    .statusReg(statusReg), .tempError(tempError)
  );

  int total = 0;
  int bad = 0;
  int cycles = 0;
  string phaseTag = "R12";
  logic checking = 1'b0;

  // reference model
  int mPhase = 0, mCnt = 0, mCipher = 0, mTemp = 0, mDone = 0;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPhase = 0; mCnt = 0; mCipher = 0; mTemp = 0; mDone = 0;
    end else begin
      int nxt;
      int rfGate;
      rfGate = (!waitRfEn || rfPresent) ? 1 : 0;
      nxt = mPhase;
      mDone = 0;
      if (abort || !cmdActive) nxt = 0;
      else if (mPhase == 0) nxt = 1;
      else if (mPhase == 1 && startSend) nxt = 2;
      else if (mPhase == 2 && mCnt >= int'(txWaitCount) && rfGate == 1) nxt = 3;
      else if (mPhase == 3 && txDone) nxt = 4;
      else if (mPhase == 4 && mCnt >= int'(rxWaitCount) && rfGate == 1) nxt = 5;
      else if (mPhase == 5 && rxStart) nxt = 6;
      else if (mPhase == 6 && rxDone) begin nxt = 0; mDone = 1; end
      if (nxt != mPhase) mCnt = 0;
      else if (mCnt < CNT_SAT) mCnt = mCnt + 1;
      mPhase = nxt;
      if (authOk) mCipher = 1;
      else if (regWrEn && !regWrCipher) mCipher = 0;
      if (overTemp) mTemp = 1;
      else if (regWrEn && regWrTempClr) mTemp = 0;
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    if (checking) begin
      check(phaseTag, "phase", int'(stateCode), mPhase);
      check("R1", "phase not 7", int'(stateCode == 3'b111), 0);
      check("R9", "txEn", int'(txEn), int'(mPhase == 3));
      check("R9", "rxEn", int'(rxEn), int'(mPhase == 5 || mPhase == 6));
      check("R8", "done", int'(done), mDone);
      check("R10", "cipher bit", int'(statusReg[3]), mCipher);
      check("R12", "status high bits", int'(statusReg[7:4]), 0);
      check("R12", "status phase field", int'(statusReg[2:0]), mPhase);
      check("R11", "tempError", int'(tempError), mTemp);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == 20000) begin
      bad++; total++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    cyc(3);
    rstN = 1'b1;
    cyc(1);
    // reset state
    check("R12", "status after reset", int'(statusReg), 0);
    check("R8", "done after reset", int'(done), 0);
    check("R11", "tempError after reset", int'(tempError), 0);
    checking = 1'b1;

    // plain exchange, no RF hold
    phaseTag = "R2";
    txWaitCount = 8'd3; rxWaitCount = 8'd2;
    cmdActive = 1; cyc(7);
    startSend = 1; cyc(1); startSend = 0;
    phaseTag = "R3"; cyc(6);
    phaseTag = "R6"; cyc(2);
    txDone = 1; cyc(1); txDone = 0;
    phaseTag = "R5"; cyc(5);
    phaseTag = "R6"; cyc(2);
    rxStart = 1; cyc(1); rxStart = 0; cyc(3);
    rxDone = 1; cyc(1); rxDone = 0;
    phaseTag = "R8"; cyc(3);

    // RF hold on both delays
    phaseTag = "R4";
    waitRfEn = 1; rfPresent = 0; txWaitCount = 8'd1; rxWaitCount = 8'd1;
    startSend = 1; cyc(1); startSend = 0; cyc(10);
    rfPresent = 1; cyc(3);
    rfPresent = 0; txDone = 1; cyc(1); txDone = 0; cyc(8);
    rfPresent = 1; cyc(3);
    rxStart = 1; cyc(1); rxStart = 0; cyc(2);

    // abort and command loss
    phaseTag = "R7";
    abort = 1; cyc(1); abort = 0; cyc(2);
    startSend = 1; cyc(1); startSend = 0; cyc(1);
    cmdActive = 0; cyc(2); cmdActive = 1; cyc(2);
    waitRfEn = 0;

    // zero-length delays, abort in receive
    phaseTag = "R3";
    txWaitCount = 8'd0; rxWaitCount = 8'd0;
    startSend = 1; cyc(1); startSend = 0; cyc(2);
    txDone = 1; cyc(1); txDone = 0; cyc(3);
    rxStart = 1; cyc(1); rxStart = 0; cyc(1);
    phaseTag = "R7"; abort = 1; rxDone = 1; cyc(1); abort = 0; rxDone = 0; cyc(3);

    // independent delay counts
    phaseTag = "R5";
    txWaitCount = 8'd1; rxWaitCount = 8'd9;
    startSend = 1; cyc(1); startSend = 0; cyc(3);
    txDone = 1; cyc(1); txDone = 0; cyc(12);
    rxStart = 1; cyc(1); rxStart = 0;
    rxDone = 1; cyc(1); rxDone = 0; cyc(2);

    // cipher flag
    authOk = 1; cyc(1); authOk = 0; cyc(1);
    regWrEn = 1; regWrCipher = 1; cyc(1); regWrEn = 0; cyc(1);
    regWrEn = 1; regWrCipher = 0; cyc(1); regWrEn = 0; cyc(1);
    authOk = 1; regWrEn = 1; regWrCipher = 0; cyc(1); authOk = 0; regWrEn = 0; cyc(1);
    regWrEn = 1; regWrCipher = 0; cyc(1); regWrEn = 0; cyc(1);

    // temperature error
    regWrCipher = 1;
    overTemp = 1; cyc(2);
    regWrEn = 1; regWrTempClr = 1; cyc(1); regWrEn = 0; regWrTempClr = 0;
    overTemp = 0; cyc(2);
    regWrEn = 1; regWrTempClr = 0; cyc(1); regWrEn = 0; cyc(1);
    regWrEn = 1; regWrTempClr = 1; cyc(1); regWrEn = 0; regWrTempClr = 0; cyc(2);

    checking = 1'b0;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule